// File: doc/BRIEF.md
# Byte Store Address Generator

This block turns the operands of a register-offset byte store into two registered requests. The first is a one-byte memory write, with its address, its data byte and an enable. The second is a base-register update, with its new value and an enable. The offset register is shifted left by zero to three places. The result is then added to or subtracted from the base value to form a candidate address. Two control bits, index and writeback, pick how the candidate is used. In offset mode the candidate is the access address and the base is left alone. In pre-indexed mode the candidate is used as the address and is also written back. In post-indexed mode the access goes to the unmodified base, and the candidate is written back afterwards.

The results appear one cycle after an input strobe. A small output state machine tracks that cycle in three states. ST_IDLE means no result is presented. ST_COMMIT means a result is presented and its requests are live. ST_SQUASH means a result is presented but both requests are suppressed, either because the condition flag was false or because the index and writeback bits were both clear. From any state, the machine takes the transition ACCEPT to ST_COMMIT on a strobe with a passing condition and a legal mode. It takes the transition REJECT to ST_SQUASH on any other strobe. It takes the transition DRAIN to ST_IDLE when there is no strobe. Reset forces ST_IDLE.

Top module: `bsa_store_agu`

## Requirements
- R1: The offset equals the offset register value shifted left by the 2-bit amount `shamt` (0 means unshifted, 3 means three places), with bits shifted past bit 31 dropped.
- R2: The candidate address is base plus offset when `add_sel`=1 and base minus offset when `add_sel`=0, wrapping modulo 2^32.
- R3: With `index_sel`=1, `mem_addr` equals the candidate address; with `index_sel`=0, `mem_addr` equals the unmodified base value.
- R4: `wb_val` always carries the candidate address. `wb_we` is 1 only for a passing, legal strobe with `wback_sel`=1, so it is 0 in offset mode (`index_sel`=1, `wback_sel`=0).
- R5: `mem_byte` equals bits 7:0 of the store data value, and `mem_we` is 1 for every passing, legal strobe.
- R6: When `cond_ok`=0, the result is still presented (`out_valid`=1), but `mem_we` and `wb_we` are both 0.
- R7: A strobe with `index_sel`=0 and `wback_sel`=0 drives `mem_we`=0, `wb_we`=0 and `bad_mode`=1, whatever the value of `cond_ok`. For every other strobe, `bad_mode` is 0.
- R8: `out_valid` is 1 exactly one cycle after each cycle with `in_valid`=1. After a cycle without a strobe, `out_valid`, `mem_we`, `wb_we` and `bad_mode` are all 0.
- R9: A synchronous active-high `rst` clears `out_valid`, `mem_we`, `wb_we` and `bad_mode` at the next rising edge, even while `in_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| base_val | input | 32 | Base register value |
| ofs_val | input | 32 | Offset register value |
| shamt | input | 2 | Left-shift amount for the offset |
| add_sel | input | 1 | 1 adds the offset, 0 subtracts it |
| index_sel | input | 1 | 1 accesses at the candidate, 0 at the base |
| wback_sel | input | 1 | 1 writes the candidate back to the base register |
| src_val | input | 32 | Store data register value |
| cond_ok | input | 1 | Condition passed |
| out_valid | output | 1 | Result presented |
| mem_we | output | 1 | Byte write enable |
| mem_addr | output | 32 | Byte write address |
| mem_byte | output | 8 | Byte to write |
| wb_we | output | 1 | Base writeback enable |
| wb_val | output | 32 | Base writeback value |
| bad_mode | output | 1 | Index and writeback were both clear |

## Verification
Each output is due exactly one rising edge after the edge that captured the strobe, with no extra latency in any mode. The driver applies one operand set, or one idle cycle, per falling edge and queues the values the requirements predict for it. The monitor samples 1 ns after the following rising edge and takes exactly one queued item per cycle. Because of this, a result that arrives a cycle early or late, or a stale enable after an idle cycle, shows up as a mismatch against the wrong item.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

    // Addressing mode, encoded as {index, writeback}
    typedef enum logic [1:0] {
        AM_BAD    = 2'b00,
        AM_POST   = 2'b01,
        AM_OFFSET = 2'b10,
        AM_PRE    = 2'b11
    } amode_e;

    // Output-stage state
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COMMIT = 2'd1,
        ST_SQUASH = 2'd2
    } ostate_e;

endpackage

// File: rtl/bsa_offset_shift.sv
module bsa_offset_shift #(
    parameter int W      = 32,
    parameter int SH_W   = 2
) (
    input  logic [W-1:0]    ofs_in,
    input  logic [SH_W-1:0] amount,
    output logic [W-1:0]    ofs_out
);
    localparam int NSH = 1 << SH_W;

    logic [W-1:0] choice [NSH];

    for (genvar k = 0; k < NSH; k++) begin : g_amt
        assign choice[k] = ofs_in << k;
    end

    assign ofs_out = choice[amount];

endmodule

// File: rtl/bsa_addsub.sv
module bsa_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         add,
    output logic [W-1:0] y
);
    always_comb begin
        if (add) y = a + b;
        else     y = a - b;
    end
endmodule

// File: rtl/bsa_mode_decode.sv
module bsa_mode_decode
    import bsa_pkg::*;
(
    input  logic   index_sel,
    input  logic   wback_sel,
    output amode_e mode,
    output logic   legal,
    output logic   wants_wb
);
    always_comb begin
        mode     = amode_e'({index_sel, wback_sel});
        legal    = 1'b1;
        wants_wb = 1'b0;
        unique case (mode)
            AM_OFFSET: wants_wb = 1'b0;
            AM_PRE:    wants_wb = 1'b1;
            AM_POST:   wants_wb = 1'b1;
            AM_BAD:    legal    = 1'b0;
            default:   legal    = 1'b0;
        endcase
    end
endmodule

// File: rtl/bsa_store_agu.sv
module bsa_store_agu
    import bsa_pkg::*;
#(
    parameter int W    = 32,
    parameter int SH_W = 2,
    parameter int BW   = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [W-1:0]    base_val,
    input  logic [W-1:0]    ofs_val,
    input  logic [SH_W-1:0] shamt,
    input  logic            add_sel,
    input  logic            index_sel,
    input  logic            wback_sel,
    input  logic [W-1:0]    src_val,
    input  logic            cond_ok,
    output logic            out_valid,
    output logic            mem_we,
    output logic [W-1:0]    mem_addr,
    output logic [BW-1:0]   mem_byte,
    output logic            wb_we,
    output logic [W-1:0]    wb_val,
    output logic            bad_mode
);
    logic [W-1:0] shifted_ofs;
    logic [W-1:0] cand_addr;
    amode_e       mode;
    logic         legal;
    logic         wants_wb;
    logic         unused_src_hi;

    assign unused_src_hi = ^src_val[W-1:BW];

    bsa_offset_shift #(.W(W), .SH_W(SH_W)) u_shift (
        .ofs_in (ofs_val),
        .amount (shamt),
        .ofs_out(shifted_ofs)
    );

    bsa_addsub #(.W(W)) u_addsub (
        .a  (base_val),
        .b  (shifted_ofs),
        .add(add_sel),
        .y  (cand_addr)
    );

    bsa_mode_decode u_mode (
        .index_sel(index_sel),
        .wback_sel(wback_sel),
        .mode     (mode),
        .legal    (legal),
        .wants_wb (wants_wb)
    );

    ostate_e state, nxt;

    // Transitions: ACCEPT, REJECT, DRAIN
    always_comb begin
        nxt = ST_IDLE;
        unique case (state)
            ST_IDLE, ST_COMMIT, ST_SQUASH: begin
                if (in_valid && legal && cond_ok) nxt = ST_COMMIT;  // ACCEPT
                else if (in_valid)                nxt = ST_SQUASH;  // REJECT
                else                              nxt = ST_IDLE;    // DRAIN
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    logic [W-1:0]  addr_q;
    logic [W-1:0]  wbv_q;
    logic [BW-1:0] byte_q;
    logic          wbreq_q;
    logic          bad_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wbv_q   <= '0;
            byte_q  <= '0;
            wbreq_q <= 1'b0;
            bad_q   <= 1'b0;
        end else if (in_valid) begin
            addr_q  <= (mode == AM_POST || mode == AM_BAD) ? base_val : cand_addr;
            wbv_q   <= cand_addr;
            byte_q  <= src_val[BW-1:0];
            wbreq_q <= wants_wb;
            bad_q   <= (mode == AM_BAD);
        end
    end

    always_comb begin
        out_valid = 1'b0;
        mem_we    = 1'b0;
        wb_we     = 1'b0;
        bad_mode  = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_COMMIT: begin
                out_valid = 1'b1;
                mem_we    = 1'b1;
                wb_we     = wbreq_q;
            end
            ST_SQUASH: begin
                out_valid = 1'b1;
                bad_mode  = bad_q;
            end
            default: ;
        endcase
        mem_addr = addr_q;
        wb_val   = wbv_q;
        mem_byte = byte_q;
    end

    a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !mem_we && !wb_we && !bad_mode));
    a_r6_cond_blocks: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !cond_ok) |=> (!mem_we && !wb_we));
    a_r7_illegal_flag: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !index_sel && !wback_sel) |=> (bad_mode && !mem_we && !wb_we));
    a_r3_post_addr: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !index_sel) |=> (mem_addr == $past(base_val)));
    a_r5_byte_lane: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (mem_byte == $past(src_val[BW-1:0])));
    a_r4_offset_no_wb: assert property (@(posedge clk) disable iff (rst)
        (in_valid && index_sel && !wback_sel) |=> !wb_we);

endmodule

// File: tb/sim_bsa_store_agu.sv
module sim_bsa_store_agu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] base_val = '0, ofs_val = '0, src_val = '0;
    logic [1:0]  shamt = '0;
    logic        add_sel = 1'b0, index_sel = 1'b0, wback_sel = 1'b0, cond_ok = 1'b0;
    logic        out_valid, mem_we, wb_we, bad_mode;
    logic [31:0] mem_addr, wb_val;
    logic [7:0]  mem_byte;

    always #2 clk = ~clk;  // 250 MHz

    bsa_store_agu u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .base_val(base_val),
        .ofs_val(ofs_val), .shamt(shamt), .add_sel(add_sel),
        .index_sel(index_sel), .wback_sel(wback_sel), .src_val(src_val),
        .cond_ok(cond_ok), .out_valid(out_valid), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_byte(mem_byte), .wb_we(wb_we),
        .wb_val(wb_val), .bad_mode(bad_mode)
    );

    typedef struct {
        logic        v, we, wbe, bad;
        logic [31:0] addr, wbv;
        logic [7:0]  b;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic op(logic [31:0] b, logic [31:0] o, logic [1:0] sh, logic ad,
                      logic ix, logic wb, logic [31:0] s, logic c);
        exp_t e;
        logic [31:0] off, cand;
        @(negedge clk);
        in_valid = 1; base_val = b; ofs_val = o; shamt = sh; add_sel = ad;
        index_sel = ix; wback_sel = wb; src_val = s; cond_ok = c;
        off  = o << sh;
        cand = ad ? b + off : b - off;
        e.v    = 1;
        e.bad  = !ix && !wb;
        e.we   = c && !e.bad;
        e.wbe  = c && wb && !e.bad;
        e.addr = ix ? cand : b;
        e.wbv  = cand;
        e.b    = s[7:0];
        q.push_back(e);
    endtask

    task automatic idle();
        exp_t e;
        @(negedge clk);
        in_valid = 0;
        base_val = 32'hDEAD_BEEF; cond_ok = 1; index_sel = 1; wback_sel = 1;
        e = '{v: 0, we: 0, wbe: 0, bad: 0, addr: 0, wbv: 0, b: 0};
        q.push_back(e);
    endtask

    // Monitor: one expected item per cycle, sampled 1 ns after the edge
    always begin
        @(posedge clk);
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk("R8 out_valid", {31'b0, out_valid}, {31'b0, e.v});
            if (e.v) begin
                chk("R5/R6/R7 mem_we", {31'b0, mem_we}, {31'b0, e.we});
                chk("R4/R6 wb_we",     {31'b0, wb_we},  {31'b0, e.wbe});
                chk("R7 bad_mode",     {31'b0, bad_mode}, {31'b0, e.bad});
                chk("R1/R2/R3 mem_addr", mem_addr, e.addr);
                chk("R1/R2/R4 wb_val",   wb_val,   e.wbv);
                chk("R5 mem_byte",     {24'b0, mem_byte}, {24'b0, e.b});
            end else begin
                chk("R8 idle mem_we", {31'b0, mem_we}, 32'd0);
                chk("R8 idle wb_we",  {31'b0, wb_we},  32'd0);
                chk("R8 idle bad",    {31'b0, bad_mode}, 32'd0);
            end
        end
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        // R9: reset holds outputs low while a legal strobe is present
        in_valid = 1; cond_ok = 1; index_sel = 1; wback_sel = 1; base_val = 32'h100;
        repeat (3) begin
            @(posedge clk); #1;
            chk("R9 out_valid", {31'b0, out_valid}, 32'd0);
            chk("R9 mem_we",    {31'b0, mem_we},    32'd0);
            chk("R9 wb_we",     {31'b0, wb_we},     32'd0);
            chk("R9 bad_mode",  {31'b0, bad_mode},  32'd0);
        end
        @(negedge clk);
        rst = 0; in_valid = 0;
        idle();
        // R1: each shift amount
        for (int k = 0; k < 4; k++) op(32'h1000, 32'h3, 2'(k), 1, 1, 0, 32'hA5, 1);
        op(32'h0, 32'hF000_0001, 2'd3, 1, 1, 0, 32'h1, 1);      // R1 bits dropped
        // R2: subtract and wrap
        op(32'h0, 32'h1, 2'd0, 0, 1, 1, 32'h11, 1);             // 0-1 -> FFFFFFFF
        op(32'hFFFF_FFFF, 32'h1, 2'd0, 1, 1, 1, 32'h22, 1);     // wraps to 0
        op(32'h8000, 32'h10, 2'd2, 0, 1, 0, 32'h33, 1);
        // R3/R4 modes
        op(32'h2000, 32'h8, 2'd1, 1, 1, 0, 32'h1234_5678, 1);   // offset
        op(32'h2000, 32'h8, 2'd1, 1, 1, 1, 32'h1234_5678, 1);   // pre
        op(32'h2000, 32'h8, 2'd1, 0, 0, 1, 32'h1234_5678, 1);   // post
        idle();
        // R7 illegal, with and without condition
        op(32'h3000, 32'h4, 2'd0, 1, 0, 0, 32'hFF, 1);
        op(32'h3000, 32'h4, 2'd0, 1, 0, 0, 32'hFF, 0);
        // R6 condition fails in each legal mode
        op(32'h4000, 32'h4, 2'd1, 1, 1, 0, 32'h77, 0);
        op(32'h4000, 32'h4, 2'd1, 1, 1, 1, 32'h77, 0);
        op(32'h4000, 32'h4, 2'd1, 0, 0, 1, 32'h77, 0);
        idle(); idle();
        // Random mix across all modes
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 7) == 0) idle();
            else op($urandom, $urandom, 2'($urandom_range(0, 3)), 1'($urandom),
                    1'($urandom), 1'($urandom), $urandom,
                    ($urandom_range(0, 5) != 0));
        end
        idle(); idle();
        wait (q.size() == 0);
        @(posedge clk); #1;
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule